// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Controller

This block connects a 32-bit host access port to an 8-bit asynchronous NAND flash device. The host selects the kind of device cycle through its byte address. One address bit raises the address latch enable, a second one raises the command latch enable, and a third one moves the access from the primary chip select to a secondary chip select, as used in multi-die packages. The two lowest address bits play no part in a device access. A wide host access is therefore carried out as four back-to-back byte cycles, taken in ascending byte lane order. A narrow access is carried out as a single byte cycle.

Every byte cycle has three phases: setup, strobe and hold. The length of each phase comes from a 32-bit timing configuration register, with separate fields for reads and for writes. When the bus changes direction (a read after a write, or a write after a read), the block first inserts idle turnaround cycles. The host is held off by a wait output until the last byte cycle has finished. Read bytes are assembled little-endian into the returned word.

A one-bit status register reports the shared ready/busy line of the flash devices after it has passed through a synchronizer.

Top module: `nand_cycle_ctrl`

## Requirements
- R1: After reset, both chip selects, write strobe and read strobe are high (inactive); latch enables, the output enable and the wait output are low; status bit 0 reads 0.
- R2: During a device access, the address latch enable equals host address bit 3 and the command latch enable equals host address bit 4. When both bits are set, only the command latch enable is driven. Neither is ever high while no chip select is active.
- R3: Host address bit 12 set selects chip select 1 (nand_cs_n = 2'b01). Clear, it selects chip select 0 (nand_cs_n = 2'b10). At most one select is low at any time, and both are high while idle.
- R4: A wide access (host_wide = 1) produces four byte cycles and a narrow one produces one. Write bytes go out least significant byte first, and a narrow write sends host_wdata[7:0].
- R5: For writes, configuration fields [29:26] (setup), [25:20] (strobe) and [19:17] (hold) holding value N each give that phase N+1 clock cycles. The write strobe is low only in the strobe phase.
- R6: For reads, fields [16:13] (setup), [12:7] (strobe) and [6:4] (hold) give N+1 cycles per phase. The read strobe is low only in the strobe phase.
- R7: Read data is sampled on the last strobe cycle of each byte and stored little-endian, with the first byte in bits [7:0]. A narrow read returns the byte in bits [7:0] with zeros above.
- R8: When a device access runs in the opposite direction to the previous one, it begins with field [3:2] + 1 idle cycles with both chip selects high. It gets no such cycles when the direction is the same or when it is the first access since reset.
- R9: host_wait rises on the cycle after a device request is accepted. It stays high for exactly the turnaround plus all phase cycles, and falls together with the end of the last hold phase.
- R10: A register write with host_reg_sel = 1 and address bit 2 = 0 loads the configuration word, and a register read of that address returns it. Bits 31, 30 and [1:0] are stored but do not change cycle timing.
- R11: A register read at address bit 2 = 1 returns bit 0 = the ready/busy input after a two-flop synchronizer (1 = ready), with zeros above.
- R12: Requests presented while host_wait is high are ignored, including configuration writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, accepted when host_wait is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 32-bit access (four byte cycles), 0 = one byte |
| host_reg_sel | input | 1 | 1 = register access, 0 = device access |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid while host_wait is low |
| host_wait | output | 1 | Host stall while a device access is in progress |
| nand_cs_n | output | 2 | Active-low chip selects (primary, secondary) |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dout | output | 8 | Data driven to the device |
| nand_oe | output | 1 | Data output enable for the device bus |
| nand_din | input | 8 | Data from the device |
| nand_rdy | input | 1 | Shared ready/busy line, low when any device is busy |

## Verification
A phase counter that is loaded wrongly shows up first in the length of a strobe pulse, and then in the total number of cycles host_wait stays high. Both are visible on the first byte of the access. A byte index that goes wrong puts bytes in the wrong order on nand_dout, or in the wrong lanes of host_rdata, and this can be seen once the access completes. A wrong direction history inserts turnaround idle cycles where none belong, or leaves them out where they are needed. That changes the count of leading cycles with both selects high while host_wait is already up. Decode faults show immediately on the latch enable and chip select pins during the first setup phase.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

  localparam int CNT_W = 6;

  typedef struct packed {
    logic       strobe_mode;
    logic       ext_wait;
    logic [3:0] w_setup;
    logic [5:0] w_strobe;
    logic [2:0] w_hold;
    logic [3:0] r_setup;
    logic [5:0] r_strobe;
    logic [2:0] r_hold;
    logic [1:0] turn;
    logic [1:0] bus_size;
  } cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  function automatic logic [CNT_W-1:0] setup_len(cfg_t c, logic we);
    return we ? CNT_W'(c.w_setup) : CNT_W'(c.r_setup);
  endfunction

  function automatic logic [CNT_W-1:0] strobe_len(cfg_t c, logic we);
    return we ? CNT_W'(c.w_strobe) : CNT_W'(c.r_strobe);
  endfunction

  function automatic logic [CNT_W-1:0] hold_len(cfg_t c, logic we);
    return we ? CNT_W'(c.w_hold) : CNT_W'(c.r_hold);
  endfunction

endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_cyc_pkg::*;
#(
  parameter logic [31:0] CFG_RESET   = 32'h3FFF_FFFC,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output cfg_t        cfg,
  input  logic        rdy_pin,
  output logic        rdy_sync
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [31:0]            cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= rdy_pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_pin};
      end
    end
  endgenerate

  assign cfg      = cfg_t'(cfg_q);
  assign rdy_sync = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/nand_addr_decode.sv
module nand_addr_decode #(
  parameter int ADDR_W  = 16,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4,
  parameter int CS2_BIT = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ale,
  output logic              cle,
  output logic              cs_sel
);

  // command latch wins when both control bits are set
  always_comb begin
    cle    = addr[CLE_BIT];
    ale    = addr[ALE_BIT] & ~addr[CLE_BIT];
    cs_sel = addr[CS2_BIT];
  end

endmodule

// File: rtl/nand_cycle_fsm.sv
module nand_cycle_fsm
  import nand_cyc_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 8,
  parameter int NCS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic              start_wide,
  input  logic              start_ale,
  input  logic              start_cle,
  input  logic              start_cs,
  input  logic [HOST_W-1:0] start_wdata,
  input  cfg_t              cfg,
  input  logic [DEV_W-1:0]  din,
  output logic [HOST_W-1:0] rword,
  output logic              busy,
  output logic [NCS-1:0]    cs_n,
  output logic              ale,
  output logic              cle,
  output logic              we_n,
  output logic              re_n,
  output logic              oe,
  output logic [DEV_W-1:0]  dout
);

  localparam int BYTES = HOST_W / DEV_W;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  phase_t            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic              we_q, ale_q, cle_q, cs_q;
  logic [HOST_W-1:0] wd_q, rbuf_q;
  logic              dir_valid_q, dir_q;
  logic              cap;
  logic              n_we, n_ale, n_cle, n_cs, act;
  logic [HOST_W-1:0] n_wd;

  always_comb begin
    n_we  = (ph_q == PH_IDLE) ? start_we    : we_q;
    n_ale = (ph_q == PH_IDLE) ? start_ale   : ale_q;
    n_cle = (ph_q == PH_IDLE) ? start_cle   : cle_q;
    n_cs  = (ph_q == PH_IDLE) ? start_cs    : cs_q;
    n_wd  = (ph_q == PH_IDLE) ? start_wdata : wd_q;

    ph_d   = ph_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    last_d = last_q;
    cap    = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          idx_d  = '0;
          last_d = start_wide ? IDX_W'(BYTES - 1) : '0;
          if (dir_valid_q && (dir_q != start_we)) begin
            ph_d  = PH_TURN;
            cnt_d = CNT_W'(cfg.turn);
          end else begin
            ph_d  = PH_SETUP;
            cnt_d = setup_len(cfg, start_we);
          end
        end
      end
      PH_TURN: begin
        if (cnt_q == '0) begin
          ph_d  = PH_SETUP;
          cnt_d = setup_len(cfg, we_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = strobe_len(cfg, we_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          cap   = 1'b1;
          ph_d  = PH_HOLD;
          cnt_d = hold_len(cfg, we_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          if (idx_q == last_q) begin
            ph_d = PH_IDLE;
          end else begin
            ph_d  = PH_SETUP;
            idx_d = idx_q + 1'b1;
            cnt_d = setup_len(cfg, we_q);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    act = (ph_d == PH_SETUP) || (ph_d == PH_STROBE) || (ph_d == PH_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      last_q      <= '0;
      we_q        <= 1'b0;
      ale_q       <= 1'b0;
      cle_q       <= 1'b0;
      cs_q        <= 1'b0;
      wd_q        <= '0;
      rbuf_q      <= '0;
      dir_valid_q <= 1'b0;
      dir_q       <= 1'b0;
      cs_n        <= '1;
      ale         <= 1'b0;
      cle         <= 1'b0;
      we_n        <= 1'b1;
      re_n        <= 1'b1;
      oe          <= 1'b0;
      dout        <= '0;
      busy        <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      if (ph_q == PH_IDLE && start) begin
        we_q        <= start_we;
        ale_q       <= start_ale;
        cle_q       <= start_cle;
        cs_q        <= start_cs;
        wd_q        <= start_wdata;
        dir_valid_q <= 1'b1;
        dir_q       <= start_we;
        if (!start_we) rbuf_q <= '0;
      end
      if (cap && !we_q) begin
        rbuf_q[idx_q*DEV_W +: DEV_W] <= din;
      end
      cs_n <= act ? ~(NCS'(1) << n_cs) : '1;
      ale  <= act & n_ale;
      cle  <= act & n_cle;
      we_n <= ~((ph_d == PH_STROBE) & n_we);
      re_n <= ~((ph_d == PH_STROBE) & ~n_we);
      oe   <= act & n_we;
      dout <= n_wd[idx_d*DEV_W +: DEV_W];
      busy <= (ph_d != PH_IDLE);
    end
  end

  assign rword = rbuf_q;

endmodule

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
  import nand_cyc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          HOST_W    = 32,
  parameter int          DEV_W     = 8,
  parameter int          ALE_BIT   = 3,
  parameter int          CLE_BIT   = 4,
  parameter int          CS2_BIT   = 12,
  parameter int          REG_BIT   = 2,
  parameter int          SYNC_STGS = 2,
  parameter logic [31:0] CFG_RESET = 32'h3FFF_FFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_wide,
  input  logic              host_reg_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_wait,
  output logic [1:0]        nand_cs_n,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DEV_W-1:0]  nand_dout,
  output logic              nand_oe,
  input  logic [DEV_W-1:0]  nand_din,
  input  logic              nand_rdy
);

  localparam int NCS = 2;

  cfg_t              cfg;
  logic              rdy_sync;
  logic              accept, dev_start, cfg_wr;
  logic              dec_ale, dec_cle, dec_cs;
  logic [HOST_W-1:0] fsm_rword, reg_rd_q;
  logic              rsel_q;

  assign accept    = host_req & ~host_wait;
  assign dev_start = accept & ~host_reg_sel;
  assign cfg_wr    = accept & host_reg_sel & host_we & ~host_addr[REG_BIT];

  nand_cfg_regs #(
    .CFG_RESET  (CFG_RESET),
    .SYNC_STAGES(SYNC_STGS)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_wr),
    .cfg_wdata(host_wdata[31:0]),
    .cfg      (cfg),
    .rdy_pin  (nand_rdy),
    .rdy_sync (rdy_sync)
  );

  nand_addr_decode #(
    .ADDR_W (ADDR_W),
    .ALE_BIT(ALE_BIT),
    .CLE_BIT(CLE_BIT),
    .CS2_BIT(CS2_BIT)
  ) i_dec (
    .addr  (host_addr),
    .ale   (dec_ale),
    .cle   (dec_cle),
    .cs_sel(dec_cs)
  );

  nand_cycle_fsm #(
    .HOST_W(HOST_W),
    .DEV_W (DEV_W),
    .NCS   (NCS)
  ) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (dev_start),
    .start_we   (host_we),
    .start_wide (host_wide),
    .start_ale  (dec_ale),
    .start_cle  (dec_cle),
    .start_cs   (dec_cs),
    .start_wdata(host_wdata),
    .cfg        (cfg),
    .din        (nand_din),
    .rword      (fsm_rword),
    .busy       (host_wait),
    .cs_n       (nand_cs_n),
    .ale        (nand_ale),
    .cle        (nand_cle),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .oe         (nand_oe),
    .dout       (nand_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      rsel_q   <= 1'b0;
    end else if (accept) begin
      rsel_q <= host_reg_sel;
      if (host_reg_sel && !host_we) begin
        reg_rd_q <= host_addr[REG_BIT] ? HOST_W'(rdy_sync) : HOST_W'(cfg);
      end
    end
  end

  assign host_rdata = rsel_q ? reg_rd_q : fsm_rword;

endmodule

// File: rtl/nand_cycle_chk.sv
module nand_cycle_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_req,
  input logic       host_reg_sel,
  input logic       host_wait,
  input logic [1:0] nand_cs_n,
  input logic       nand_ale,
  input logic       nand_cle,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_oe
);

  a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~nand_cs_n));

  a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(nand_ale && nand_cle));

  a_r2_latch_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (nand_ale || nand_cle) |-> (nand_cs_n != 2'b11));

  a_r4_strobe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n || nand_oe) |-> (nand_cs_n != 2'b11));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  a_r9_wait_on_start: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_reg_sel && !host_wait) |=> host_wait);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !host_wait |-> (nand_cs_n == 2'b11 && nand_we_n && nand_re_n));

endmodule

bind nand_cycle_ctrl nand_cycle_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .host_req    (host_req),
  .host_reg_sel(host_reg_sel),
  .host_wait   (host_wait),
  .nand_cs_n   (nand_cs_n),
  .nand_ale    (nand_ale),
  .nand_cle    (nand_cle),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_oe     (nand_oe)
);

// File: tb/test_nand_cycle_ctrl.sv
`timescale 1ns/1ps
module test_nand_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0, host_wide = 1'b0, host_reg_sel = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_wait;
  logic [1:0]  nand_cs_n;
  logic        nand_ale, nand_cle, nand_we_n, nand_re_n, nand_oe;
  logic [7:0]  nand_dout, nand_din;
  logic        nand_rdy = 1'b0;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  logic [7:0] dev_mem [0:3];
  int ridx = 0;
  assign nand_din = dev_mem[ridx[1:0]];
  always @(posedge nand_re_n) ridx <= ridx + 1;

  always #5 clk = ~clk;

  nand_cycle_ctrl i_nand_cycle_ctrl (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_wide(host_wide), .host_reg_sel(host_reg_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_wait(host_wait),
    .nand_cs_n(nand_cs_n), .nand_ale(nand_ale), .nand_cle(nand_cle),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout),
    .nand_oe(nand_oe), .nand_din(nand_din), .nand_rdy(nand_rdy)
  );

  // recorded samples of one device access
  logic [1:0] r_cs  [0:1023];
  logic       r_ale [0:1023];
  logic       r_cle [0:1023];
  logic       r_we  [0:1023];
  logic       r_re  [0:1023];
  logic [7:0] r_do  [0:1023];
  int nrec;

  bit have_last = 0;
  bit last_we   = 0;
  logic [31:0] cur_cfg;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(int ws, int wst, int wh, int rs, int rst_, int rh, int ta);
    return (32'(ws) << 26) | (32'(wst) << 20) | (32'(wh) << 17) |
           (32'(rs) << 13) | (32'(rst_) << 7) | (32'(rh) << 4) | (32'(ta) << 2);
  endfunction

  function automatic int phase_sum(bit we, logic [31:0] c);
    if (we) return int'(c[29:26]) + int'(c[25:20]) + int'(c[19:17]) + 3;
    return int'(c[16:13]) + int'(c[12:7]) + int'(c[6:4]) + 3;
  endfunction

  function automatic int turn_len(bit we, logic [31:0] c);
    if (have_last && last_we != we) return int'(c[3:2]) + 1;
    return 0;
  endfunction

  task automatic reg_write(input bit stat, input logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_reg_sel = 1; host_we = 1; host_addr = stat ? 16'h4 : 16'h0; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_reg_sel = 0;
  endtask

  task automatic reg_read(input bit stat, output logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_reg_sel = 1; host_we = 0; host_addr = stat ? 16'h4 : 16'h0;
    @(negedge clk);
    host_req = 0; host_reg_sel = 0;
    d = host_rdata;
  endtask

  task automatic run_dev(input bit we, input bit wide, input logic [15:0] addr, input logic [31:0] wd);
    ridx = 0;
    @(negedge clk);
    host_req = 1; host_reg_sel = 0; host_we = we; host_wide = wide; host_addr = addr; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    nrec = 0;
    forever begin
      r_cs[nrec] = nand_cs_n; r_ale[nrec] = nand_ale; r_cle[nrec] = nand_cle;
      r_we[nrec] = nand_we_n; r_re[nrec] = nand_re_n; r_do[nrec] = nand_dout;
      if (!host_wait || nrec == 1023) break;
      nrec++;
      @(negedge clk);
    end
  endtask

  // checks timing, decode and data of the recorded access
  task automatic check_access(input string tag, input bit we, input bit wide,
                              input logic [1:0] ecs, input bit eale, input bit ecle,
                              input logic [31:0] wd);
    int lead = 0, first = -1, strobes = 0, nb = 0, badctl = 0, turn, exp_w;
    int nbytes = wide ? 4 : 1;
    turn  = turn_len(we, cur_cfg);
    exp_w = turn + nbytes * phase_sum(we, cur_cfg);
    while (lead < nrec && r_cs[lead] == 2'b11) lead++;
    for (int i = 0; i < nrec; i++) begin
      logic s;
      s = we ? r_we[i] : r_re[i];
      if (!s) begin
        strobes++;
        if (first < 0) first = i;
        if (we && (i == 0 || r_we[i-1])) begin
          if (nb < 4 && r_do[i] != wd[nb*8 +: 8])
            check(0, "R4", "write byte", r_do[i], wd[nb*8 +: 8]);
          nb++;
        end
      end
      if (r_cs[i] != 2'b11 && (r_cs[i] != ecs || r_ale[i] != eale || r_cle[i] != ecle)) badctl++;
    end
    check(nrec == exp_w, "R9", {tag, " wait cycles"}, nrec, exp_w);
    check(lead == turn, "R8", {tag, " turnaround idle"}, lead, turn);
    check(badctl == 0 && r_cs[lead] == ecs, "R2", {tag, " ale/cle/cs decode"}, badctl, 0);
    check(r_cs[lead] == ecs, "R3", {tag, " chip select"}, r_cs[lead], ecs);
    if (we) begin
      check(first - lead == int'(cur_cfg[29:26]) + 1, "R5", {tag, " write setup"}, first - lead, int'(cur_cfg[29:26]) + 1);
      check(strobes == nbytes * (int'(cur_cfg[25:20]) + 1), "R5", {tag, " write strobe total"}, strobes, nbytes * (int'(cur_cfg[25:20]) + 1));
      check(nb == nbytes, "R4", {tag, " write byte count"}, nb, nbytes);
    end else begin
      check(first - lead == int'(cur_cfg[16:13]) + 1, "R6", {tag, " read setup"}, first - lead, int'(cur_cfg[16:13]) + 1);
      check(strobes == nbytes * (int'(cur_cfg[12:7]) + 1), "R6", {tag, " read strobe total"}, strobes, nbytes * (int'(cur_cfg[12:7]) + 1));
    end
    have_last = 1;
    last_we   = we;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(nand_cs_n == 2'b11 && nand_we_n && nand_re_n, "R1", "strobes/selects idle", {nand_cs_n, nand_we_n, nand_re_n}, 4'hF);
    check(!nand_ale && !nand_cle && !nand_oe && !host_wait, "R1", "latch/oe/wait low", {nand_ale, nand_cle, nand_oe, host_wait}, 0);
    reg_read(1, d);
    check(d == 32'h0, "R1", "status after reset", d, 0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] d;
    cur_cfg = mk_cfg(1, 2, 0, 0, 1, 1, 2);
    reg_write(0, cur_cfg);
    reg_read(0, d);
    check(d == cur_cfg, "R10", "config readback", d, cur_cfg);
  endtask

  task automatic t_write_wide();
    run_dev(1, 1, 16'h0010, 32'hA1B2C3D4);
    check_access("write wide cle", 1, 1, 2'b10, 0, 1, 32'hA1B2C3D4);
  endtask

  task automatic t_read_wide();
    dev_mem[0] = 8'h11; dev_mem[1] = 8'h22; dev_mem[2] = 8'h33; dev_mem[3] = 8'h44;
    run_dev(0, 1, 16'h1008, 32'h0);
    check(host_rdata == 32'h44332211, "R7", "wide read assembly", host_rdata, 32'h44332211);
    check_access("read wide ale cs1", 0, 1, 2'b01, 1, 0, 32'h0);
  endtask

  task automatic t_read_narrow();
    dev_mem[0] = 8'h5A; dev_mem[1] = 8'hFF;
    run_dev(0, 0, 16'h0003, 32'h0);
    check(host_rdata == 32'h0000005A, "R7", "narrow read", host_rdata, 32'h5A);
    check_access("read narrow", 0, 0, 2'b10, 0, 0, 32'h0);
  endtask

  task automatic t_both_bits();
    run_dev(1, 0, 16'h0018, 32'hCCDDEE77);
    check_access("write narrow both bits", 1, 0, 2'b10, 0, 1, 32'hCCDDEE77);
  endtask

  task automatic t_mode_bits();
    logic [31:0] d;
    cur_cfg = mk_cfg(2, 1, 1, 0, 1, 1, 2) | 32'hC000_0003;
    reg_write(0, cur_cfg);
    reg_read(0, d);
    check(d == cur_cfg, "R10", "config readback with mode bits", d, cur_cfg);
    run_dev(1, 1, 16'h0000, 32'h01020304);
    check_access("R10 mode bits ignored", 1, 1, 2'b10, 0, 0, 32'h01020304);
  endtask

  task automatic t_ignore_busy();
    logic [31:0] d;
    int n = 0;
    @(negedge clk);
    host_req = 1; host_reg_sel = 0; host_we = 1; host_wide = 1; host_addr = 16'h0; host_wdata = 32'h0;
    @(negedge clk);
    host_req = 1; host_reg_sel = 1; host_we = 1; host_addr = 16'h0; host_wdata = 32'h0;
    @(negedge clk);
    host_req = 0; host_reg_sel = 0;
    while (host_wait && n < 2000) begin @(negedge clk); n++; end
    have_last = 1; last_we = 1;
    reg_read(0, d);
    check(d == cur_cfg, "R12", "config write while busy ignored", d, cur_cfg);
  endtask

  task automatic t_status();
    logic [31:0] d;
    nand_rdy = 1;
    repeat (3) @(negedge clk);
    reg_read(1, d);
    check(d == 32'h1, "R11", "status ready", d, 1);
    nand_rdy = 0;
    repeat (3) @(negedge clk);
    reg_read(1, d);
    check(d == 32'h0, "R11", "status busy", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_write_wide();
    t_read_wide();
    t_read_narrow();
    t_both_bits();
    t_mode_bits();
    t_ignore_busy();
    t_status();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule